// File: doc/BRIEF.md
# Coherent Multi-Byte Measurement Read Latch

This block lets an 8-bit processor bus read 24-bit measurement values, such as waveform samples and RMS results, that a producer keeps changing on every clock. Each value is presented as three byte registers: low, middle and high. A read of the high byte freezes a copy of all 24 bits, so the middle and low bytes read afterwards belong to the same sample even if the live value has moved on.

Lower bytes are served only from the frozen copy. A read of the middle or low byte that is not preceded by a high-byte read therefore returns data from the previous capture. The block also has a set of byte-wide interrupt-status registers. These have no snapshot: each byte is captured from its live source at the moment that byte is read. Every quantity keeps its own snapshot, and the read data is registered, so it appears on the bus output one clock after the read strobe.

Top module: `snap_latch_top`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_data` is 0x00 and every snapshot holds zero, so a low or middle read before any high read returns 0x00.
- R2: A read of address 4q+2 (high byte of quantity q) puts bits 23:16 of that quantity's live value, sampled at the strobe edge, on `rd_data` one clock after the strobe.
- R3: The same high-byte read loads all 24 bits of the live value into quantity q's snapshot at that edge.
- R4: Reads of address 4q+1 (middle byte, bits 15:8) and 4q+0 (low byte, bits 7:0) return the snapshot and never the live value. Such reads leave the snapshot unchanged.
- R5: A high-byte read of one quantity leaves the snapshots of all other quantities unchanged.
- R6: A read of address 0x40+i, with i below the number of status bytes, returns status byte i as sampled at the strobe edge.
- R7: A read of any other address returns 0x00. This includes offset 4q+3, a quantity index at or above the configured count, a status index out of range, and addresses 0x80 to 0xFF.
- R8: While `rd_en` is low, `rd_data` holds its last value and no snapshot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 8 | Byte address of the register read |
| live_val | input | NUM_QTY*24 | Live 24-bit values; quantity q occupies bits 24q+23:24q |
| irq_live | input | NUM_IRQ*8 | Live status bytes; byte i occupies bits 8i+7:8i |
| rd_data | output | 8 | Registered read data, valid the clock after the strobe |

## Verification
The hardest case to reach is a lower-byte read whose snapshot differs from the live value on the same cycle. Only that case shows that the byte came from the frozen copy and not from the live value. The stimulus table changes the live value on every read after a high-byte capture and inserts idle cycles between reads. Directed steps then capture a second quantity while the first still holds an older sample, and issue lower-byte reads straight after a mid-run reset.

// File: rtl/snap_pkg.sv
package snap_pkg;

  localparam int unsigned WORD_W   = 24;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [1:0]  REGION_QTY = 2'b00;
  localparam logic [1:0]  REGION_IRQ = 2'b01;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } byte_sel_e;

  typedef struct packed {
    logic      hit_qty;
    logic      hit_irq;
    logic [3:0] qidx;
    logic [5:0] iidx;
    byte_sel_e sel;
  } rd_dec_t;

endpackage

// File: rtl/snap_rst_sync.sv
module snap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/snap_rd_decode.sv
module snap_rd_decode
  import snap_pkg::*;
#(
  parameter int unsigned NUM_QTY = 4,
  parameter int unsigned NUM_IRQ = 3
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output rd_dec_t           dec
);
  localparam logic [4:0] QTY_LIM = 5'(NUM_QTY);
  localparam logic [6:0] IRQ_LIM = 7'(NUM_IRQ);

  logic in_qty_region;
  logic in_irq_region;
  logic qidx_ok;
  logic iidx_ok;
  logic sel_ok;

  always_comb begin
    in_qty_region = (rd_addr[7:6] == REGION_QTY);
    in_irq_region = (rd_addr[7:6] == REGION_IRQ);
    qidx_ok       = ({1'b0, rd_addr[5:2]} < QTY_LIM);
    iidx_ok       = ({1'b0, rd_addr[5:0]} < IRQ_LIM);
    sel_ok        = (rd_addr[1:0] != SEL_NONE);

    dec.qidx    = rd_addr[5:2];
    dec.iidx    = rd_addr[5:0];
    dec.sel     = byte_sel_e'(rd_addr[1:0]);
    dec.hit_qty = rd_en && in_qty_region && qidx_ok && sel_ok;
    dec.hit_irq = rd_en && in_irq_region && iidx_ok;
  end
endmodule

// File: rtl/snap_word_latch.sv
module snap_word_latch #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         cap_en,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (cap_en) snap_d = live;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= snap_d;
  end

  assign snap = snap_q;
endmodule

// File: rtl/snap_latch_top.sv
module snap_latch_top
  import snap_pkg::*;
#(
  parameter int unsigned NUM_QTY = 4,
  parameter int unsigned NUM_IRQ = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [7:0]                rd_addr,
  input  logic [NUM_QTY*24-1:0]     live_val,
  input  logic [NUM_IRQ*8-1:0]      irq_live,
  output logic [7:0]                rd_data
);
  localparam int unsigned QW = (NUM_QTY > 1) ? $clog2(NUM_QTY) : 1;
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic                  rst_sync_n;
  rd_dec_t               dec;
  logic [WORD_W-1:0]     live_arr [NUM_QTY];
  logic [WORD_W-1:0]     snap_arr [NUM_QTY];
  logic [BYTE_W-1:0]     irq_arr  [NUM_IRQ];
  logic [NUM_QTY*24-1:0] snap_flat;
  logic [NUM_QTY-1:0]    cap_en;
  logic [BYTE_W-1:0]     rd_data_q;
  logic [BYTE_W-1:0]     rd_data_d;
  logic [WORD_W-1:0]     sel_live;
  logic [WORD_W-1:0]     sel_snap;
  logic [BYTE_W-1:0]     sel_irq;

  snap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  snap_rd_decode #(.NUM_QTY(NUM_QTY), .NUM_IRQ(NUM_IRQ)) u_decode (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .dec     (dec)
  );

  for (genvar q = 0; q < NUM_QTY; q++) begin : g_qty
    assign live_arr[q] = live_val[q*24 +: 24];
    assign cap_en[q]   = dec.hit_qty && (dec.sel == SEL_HI) &&
                         (dec.qidx == 4'(q));

    snap_word_latch #(.W(WORD_W)) u_latch (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .cap_en (cap_en[q]),
      .live   (live_arr[q]),
      .snap   (snap_arr[q])
    );

    assign snap_flat[q*24 +: 24] = snap_arr[q];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_arr[i] = irq_live[i*8 +: 8];
  end

  always_comb begin
    sel_live = live_arr[dec.qidx[QW-1:0]];
    sel_snap = snap_arr[dec.qidx[QW-1:0]];
    sel_irq  = irq_arr[dec.iidx[IW-1:0]];
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) begin
      rd_data_d = '0;
      if (dec.hit_qty) begin
        unique case (dec.sel)
          SEL_HI:  rd_data_d = sel_live[23:16];
          SEL_MID: rd_data_d = sel_snap[15:8];
          SEL_LO:  rd_data_d = sel_snap[7:0];
          default: rd_data_d = '0;
        endcase
      end else if (dec.hit_irq) begin
        rd_data_d = sel_irq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data_q <= '0;
    else             rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/snap_latch_chk.sv
module snap_latch_chk #(
  parameter int unsigned NUM_QTY = 4,
  parameter int unsigned NUM_IRQ = 3
) (
  input logic                  clk,
  input logic                  rst_ni,
  input logic                  rd_en,
  input logic [7:0]            rd_addr,
  input logic [NUM_QTY*24-1:0] live_val,
  input logic [NUM_IRQ*8-1:0]  irq_live,
  input logic [NUM_QTY*24-1:0] snap_flat,
  input logic [7:0]            rd_data
);
  for (genvar q = 0; q < NUM_QTY; q++) begin : g_q
    localparam logic [7:0] A_LO  = 8'(q*4);
    localparam logic [7:0] A_MID = 8'(q*4 + 1);
    localparam logic [7:0] A_HI  = 8'(q*4 + 2);

    a_r2_high_byte: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_en && rd_addr == A_HI) |=> rd_data == $past(live_val[q*24+16 +: 8]));

    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_en && rd_addr == A_HI) |=> snap_flat[q*24 +: 24] == $past(live_val[q*24 +: 24]));

    a_r4_mid_snap: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_en && rd_addr == A_MID) |=> rd_data == $past(snap_flat[q*24+8 +: 8]));

    a_r4_lo_snap: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_en && rd_addr == A_LO) |=> rd_data == $past(snap_flat[q*24 +: 8]));

    a_r5_isolated: assert property (@(posedge clk) disable iff (!rst_ni)
      !(rd_en && rd_addr == A_HI) |=> $stable(snap_flat[q*24 +: 24]));
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_i
    localparam logic [7:0] A_IRQ = 8'(8'h40 + i);
    a_r6_irq_byte: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_en && rd_addr == A_IRQ) |=> rd_data == $past(irq_live[i*8 +: 8]));
  end

  a_r7_gap_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && rd_addr[7]) |=> rd_data == 8'h00);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data));
endmodule

bind snap_latch_top snap_latch_chk #(.NUM_QTY(NUM_QTY), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .live_val  (live_val),
  .irq_live  (irq_live),
  .snap_flat (snap_flat),
  .rd_data   (rd_data)
);

// File: tb/test_snap_latch_top.sv
module test_snap_latch_top;
  localparam int unsigned NQ = 4;
  localparam int unsigned NI = 3;
  localparam int unsigned NV = 12;

  logic             clk;
  logic             rst_n;
  logic             rd_en;
  logic [7:0]       rd_addr;
  logic [NQ*24-1:0] live_val;
  logic [NI*8-1:0]  irq_live;
  logic [7:0]       rd_data;

  int checks;
  int errors;
  bit done;

  // {req[3:0], rd_en, addr[7:0], live q0[23:0], expected[7:0]}
  localparam logic [44:0] VEC [NV] = '{
    {4'd4, 1'b1, 8'h00, 24'hA1B2C3, 8'h00}, // R4 low before any capture
    {4'd2, 1'b1, 8'h02, 24'hA1B2C3, 8'hA1}, // R2 high byte
    {4'd3, 1'b1, 8'h01, 24'h112233, 8'hB2}, // R3 mid from capture
    {4'd3, 1'b1, 8'h00, 24'h445566, 8'hC3}, // R3 low from capture
    {4'd8, 1'b0, 8'h02, 24'h778899, 8'hC3}, // R8 idle holds
    {4'd4, 1'b1, 8'h00, 24'h778899, 8'hC3}, // R4 idle did not capture
    {4'd2, 1'b1, 8'h02, 24'h778899, 8'h77}, // R2 new capture
    {4'd3, 1'b1, 8'h00, 24'h000000, 8'h99}, // R3
    {4'd3, 1'b1, 8'h01, 24'hFFFFFF, 8'h88}, // R3
    {4'd7, 1'b1, 8'h03, 24'hFFFFFF, 8'h00}, // R7 offset 3
    {4'd7, 1'b1, 8'h80, 24'hFFFFFF, 8'h00}, // R7 upper region
    {4'd4, 1'b1, 8'h01, 24'hDEADBE, 8'h88}  // R4 repeat read unchanged
  };

  snap_latch_top #(.NUM_QTY(NQ), .NUM_IRQ(NI)) i_snap_latch_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .live_val (live_val),
    .irq_live (irq_live),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data=%02h expected=%02h", req, rd_data, exp);
    end
  endtask

  // drive a read at a falling edge, sample at the next falling edge
  task automatic rd(input logic en, input logic [7:0] a);
    rd_en   = en;
    rd_addr = a;
    @(negedge clk);
    rd_en   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rd_en = 1'b0; rd_addr = '0; live_val = '0; irq_live = '0;
    @(negedge clk);
    do_reset();
    check("R1", 8'h00);

    for (int k = 0; k < NV; k++) begin
      live_val[23:0] = VEC[k][31:8];
      rd(VEC[k][40], VEC[k][39:32]);
      checks++;
      if (rd_data !== VEC[k][7:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d rd_data=%02h expected=%02h",
                 VEC[k][44:41], k, rd_data, VEC[k][7:0]);
      end
    end

    // R5: capture quantity 1, quantity 0 snapshot untouched
    live_val[47:24] = 24'h123456;
    live_val[23:0]  = 24'hCAFE00;
    rd(1'b1, 8'h06); check("R5", 8'h12);
    live_val[47:24] = 24'h999999;
    rd(1'b1, 8'h00); check("R5", 8'h99);
    rd(1'b1, 8'h04); check("R5", 8'h56);
    rd(1'b1, 8'h05); check("R5", 8'h34);
    // quantity 3 high and low
    live_val[95:72] = 24'hF0E1D2;
    rd(1'b1, 8'h0E); check("R2", 8'hF0);
    rd(1'b1, 8'h0C); check("R3", 8'hD2);

    // R6: status bytes sampled at the read
    irq_live = {8'h77, 8'h3C, 8'h5A};
    rd(1'b1, 8'h40); check("R6", 8'h5A);
    irq_live[7:0] = 8'hA5;
    rd(1'b1, 8'h40); check("R6", 8'hA5);
    rd(1'b1, 8'h42); check("R6", 8'h77);
    irq_live[23:16] = 8'h00;
    rd(1'b0, 8'h42); check("R8", 8'h77);

    // R7: out-of-range indices
    rd(1'b1, 8'h43); check("R7", 8'h00);
    rd(1'b1, 8'h41); check("R6", 8'h3C);
    rd(1'b1, 8'h12); check("R7", 8'h00);

    // R1: mid-run reset clears snapshots
    do_reset();
    check("R1", 8'h00);
    rd(1'b1, 8'h01); check("R1", 8'h00);
    rd(1'b1, 8'h04); check("R1", 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule